// File: doc/BRIEF.md
# Card Controller Interrupt and DMA Request Router

This block collects the event pulses of a memory-card controller into a bank of sticky request bits. It qualifies them with a software mask and drives a single CPU interrupt line. When the controller runs in DMA mode, the receive and transmit FIFO service requests are taken out of the CPU interrupt path. They then drive two dedicated DMA request lines, level-sensitive, for as long as the request bits stay set.

The block also holds the card clock's run/stop state. A start command marks the clock as running and withdraws the clock-off request. A stop command marks it stopped, raises the clock-off request and emits a one-cycle abort pulse toward the transfer sequencer. All outputs are registered, so the interrupt and DMA lines never glitch. An event or register write becomes visible in `req_o`/`mask_o`/`clk_run_o` after one clock edge, and in `irq_o`/`dma_rx_req_o`/`dma_tx_req_o` after two.

Top module: `irq_dma_router`

## Requirements
- R1: After reset, every request bit and mask bit is 0, the clock is marked stopped, and the interrupt, both DMA request lines and the abort pulse are low.
- R2: An event pulse on bit i (0 data done, 1 program done, 2 end command, 3 stop command, 4 clock off, 5 RX FIFO, 6 TX FIFO, 7 timeout, 8 data error, 9 response error, 10 read stalled, 11 card interrupt, 12 suspend ack) sets request bit i one edge later, and the bit stays set until cleared.
- R3: A clear write removes the request bits given as ones in its data and leaves the others untouched; an event on the same bit in the same cycle wins and the bit stays set.
- R4: A mask write loads all 13 mask bits and they read back on `mask_o` one edge later; a mask bit of 1 suppresses the matching request from the interrupt.
- R5: One edge after the request and mask state settle, `irq_o` is high exactly when some request bit is set whose effective mask bit is clear.
- R6: With DMA mode on, request bits 5 and 6 are masked from `irq_o` whatever the mask holds, and `dma_rx_req_o`/`dma_tx_req_o` follow request bits 5/6.
- R7: With DMA mode off, both DMA request lines stay low whatever the request bits hold.
- R8: A clock-control write with data bit 1 set (and bit 0 clear) marks the clock running and clears request bit 4.
- R9: A clock-control write with data bit 0 set marks the clock stopped, sets request bit 4 and drives `xfer_abort_o` high for exactly one cycle; when bits 0 and 1 are both set, the stop wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| event_i | input | 13 | One-cycle event pulses, one per request bit |
| clr_we_i | input | 1 | Request clear write strobe |
| clr_data_i | input | 13 | Ones select request bits to clear |
| mask_we_i | input | 1 | Mask write strobe |
| mask_data_i | input | 13 | New mask value |
| dma_en_i | input | 1 | DMA mode enable from the control word |
| clk_wr_i | input | 1 | Clock control write strobe |
| clk_data_i | input | 2 | Bit 1 start clock, bit 0 stop clock |
| irq_o | output | 1 | CPU interrupt, registered |
| dma_rx_req_o | output | 1 | Receive DMA request, registered |
| dma_tx_req_o | output | 1 | Transmit DMA request, registered |
| clk_run_o | output | 1 | Clock-running status |
| xfer_abort_o | output | 1 | One-cycle pulse on a clock stop |
| req_o | output | 13 | Request bits |
| mask_o | output | 13 | Mask bits |

## Verification
The hardest case is a combination that needs several writes set up in the right cycles: the only unmasked request is a FIFO request while DMA mode is on, so the interrupt must stay low and exactly one DMA line must rise. The bench sweeps every request bit against the full mask state matrix. In each pass it first clears all requests, then masks either only the bit under test or every other bit, and toggles DMA mode. It then pulses the single event, so each outcome depends on one bit alone. A clear and an event on the same bit are also driven in the same cycle, and a clock write with start and stop both set is used to probe the priority orderings.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam int SRC_W       = 13;
    localparam int BIT_CLK_OFF = 4;
    localparam int BIT_RX_FIFO = 5;
    localparam int BIT_TX_FIFO = 6;
    localparam int CLK_CMD_W   = 2;
    localparam int CMD_STOP    = 0;
    localparam int CMD_START   = 1;
endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
    parameter int N = irq_router_pkg::SRC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] req_o
);
    typedef struct packed {
        logic [N-1:0] req;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < N; b++) begin
            // set has priority over a same-cycle clear
            st_d.req[b] = set_i[b] | (st_q.req[b] & ~clr_i[b]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.req;

    assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((req_o & $past(set_i)) == $past(set_i)));

    assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((req_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/irq_clk_ctrl.sv
module irq_clk_ctrl #(
    parameter int CMD_W   = irq_router_pkg::CLK_CMD_W,
    parameter int STOP_B  = irq_router_pkg::CMD_STOP,
    parameter int START_B = irq_router_pkg::CMD_START
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CMD_W-1:0] data_i,
    output logic             clkoff_set_o,
    output logic             clkoff_clr_o,
    output logic             run_o,
    output logic             abort_o
);
    typedef struct packed {
        logic run;
        logic abort;
    } clk_st_t;

    clk_st_t st_d, st_q;
    logic    do_stop, do_start;

    always_comb begin
        do_stop  = wr_i & data_i[STOP_B];
        do_start = wr_i & data_i[START_B] & ~data_i[STOP_B];
        st_d       = st_q;
        st_d.abort = do_stop;
        if (do_start) st_d.run = 1'b1;
        if (do_stop)  st_d.run = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clkoff_set_o = do_stop;
    assign clkoff_clr_o = do_start;
    assign run_o        = st_q.run;
    assign abort_o      = st_q.abort;

    assert_abort_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> !run_o);
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
    parameter int N    = irq_router_pkg::SRC_W,
    parameter int RX_B = irq_router_pkg::BIT_RX_FIFO,
    parameter int TX_B = irq_router_pkg::BIT_TX_FIFO
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we_i,
    input  logic [N-1:0] mask_wdata_i,
    input  logic         dma_en_i,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] mask_o,
    output logic         irq_o,
    output logic         rx_req_o,
    output logic         tx_req_o
);
    localparam logic [N-1:0] ROUTED = ({{(N-1){1'b0}}, 1'b1} << RX_B)
                                    | ({{(N-1){1'b0}}, 1'b1} << TX_B);

    typedef struct packed {
        logic [N-1:0] mask;
        logic         dma;
        logic         irq;
        logic         rx;
        logic         tx;
    } out_st_t;

    out_st_t      st_d, st_q;
    logic [N-1:0] eff_mask;

    always_comb begin
        st_d     = st_q;
        eff_mask = st_q.mask | (st_q.dma ? ROUTED : '0);
        if (mask_we_i) st_d.mask = mask_wdata_i;
        st_d.dma = dma_en_i;
        st_d.irq = |(req_i & ~eff_mask);
        st_d.rx  = st_q.dma & req_i[RX_B];
        st_d.tx  = st_q.dma & req_i[TX_B];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o   = st_q.mask;
    assign irq_o    = st_q.irq;
    assign rx_req_o = st_q.rx;
    assign tx_req_o = st_q.tx;

    assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we_i |=> (mask_o == $past(mask_wdata_i)));

    assert_irq_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.dma && ((req_i & ~st_q.mask) != '0)) |=> irq_o);

    assert_fifo_hidden_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dma && ((req_i & ~st_q.mask & ~ROUTED) == '0)) |=> !irq_o);

    assert_dma_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.dma |=> (rx_req_o == $past(req_i[RX_B]) && tx_req_o == $past(req_i[TX_B])));

    assert_dma_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.dma |=> (!rx_req_o && !tx_req_o));
endmodule

// File: rtl/irq_dma_router.sv
module irq_dma_router #(
    parameter int N         = irq_router_pkg::SRC_W,
    parameter int CLKOFF_B  = irq_router_pkg::BIT_CLK_OFF,
    parameter int RX_B      = irq_router_pkg::BIT_RX_FIFO,
    parameter int TX_B      = irq_router_pkg::BIT_TX_FIFO,
    parameter int CMD_W     = irq_router_pkg::CLK_CMD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     event_i,
    input  logic             clr_we_i,
    input  logic [N-1:0]     clr_data_i,
    input  logic             mask_we_i,
    input  logic [N-1:0]     mask_data_i,
    input  logic             dma_en_i,
    input  logic             clk_wr_i,
    input  logic [CMD_W-1:0] clk_data_i,
    output logic             irq_o,
    output logic             dma_rx_req_o,
    output logic             dma_tx_req_o,
    output logic             clk_run_o,
    output logic             xfer_abort_o,
    output logic [N-1:0]     req_o,
    output logic [N-1:0]     mask_o
);
    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    logic         clkoff_set, clkoff_clr;
    logic [N-1:0] set_vec, clr_vec;

    always_comb begin
        set_vec = event_i | (clkoff_set ? (ONE << CLKOFF_B) : '0);
        clr_vec = (clr_we_i ? clr_data_i : '0) | (clkoff_clr ? (ONE << CLKOFF_B) : '0);
    end

    irq_clk_ctrl #(.CMD_W(CMD_W)) u_clk (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (clk_wr_i),
        .data_i       (clk_data_i),
        .clkoff_set_o (clkoff_set),
        .clkoff_clr_o (clkoff_clr),
        .run_o        (clk_run_o),
        .abort_o      (xfer_abort_o)
    );

    irq_req_bank #(.N(N)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (clr_vec),
        .req_o (req_o)
    );

    irq_out_stage #(.N(N), .RX_B(RX_B), .TX_B(TX_B)) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .mask_we_i    (mask_we_i),
        .mask_wdata_i (mask_data_i),
        .dma_en_i     (dma_en_i),
        .req_i        (req_o),
        .mask_o       (mask_o),
        .irq_o        (irq_o),
        .rx_req_o     (dma_rx_req_o),
        .tx_req_o     (dma_tx_req_o)
    );

    assert_stop_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_wr_i && clk_data_i[0]) |=> (!clk_run_o && req_o[CLKOFF_B] && xfer_abort_o));

    assert_start_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_wr_i && clk_data_i[1] && !clk_data_i[0] && !event_i[CLKOFF_B])
            |=> (clk_run_o && !req_o[CLKOFF_B]));
endmodule

// File: tb/irq_dma_router_bench.sv
`timescale 1ns/1ps
module irq_dma_router_bench;
    localparam int N = 13;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] event_i = '0;
    logic         clr_we_i = 1'b0;
    logic [N-1:0] clr_data_i = '0;
    logic         mask_we_i = 1'b0;
    logic [N-1:0] mask_data_i = '0;
    logic         dma_en_i = 1'b0;
    logic         clk_wr_i = 1'b0;
    logic [1:0]   clk_data_i = '0;
    logic         irq_o, dma_rx_req_o, dma_tx_req_o, clk_run_o, xfer_abort_o;
    logic [N-1:0] req_o, mask_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_dma_router u_irq_dma_router (
        .clk(clk), .rst_n(rst_n), .event_i(event_i), .clr_we_i(clr_we_i),
        .clr_data_i(clr_data_i), .mask_we_i(mask_we_i), .mask_data_i(mask_data_i),
        .dma_en_i(dma_en_i), .clk_wr_i(clk_wr_i), .clk_data_i(clk_data_i),
        .irq_o(irq_o), .dma_rx_req_o(dma_rx_req_o), .dma_tx_req_o(dma_tx_req_o),
        .clk_run_o(clk_run_o), .xfer_abort_o(xfer_abort_o), .req_o(req_o), .mask_o(mask_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1 reset state
        chk("R1 req", 32'(req_o), 0);
        chk("R1 mask", 32'(mask_o), 0);
        chk("R1 irq/dma/run/abort", {27'd0, irq_o, dma_rx_req_o, dma_tx_req_o, clk_run_o, xfer_abort_o}, 0);
        rst_n = 1'b1;
        tick();

        // R2 R4 R5 R6 R7 sweep: every bit x mask-own/mask-others x dma off/on
        for (int b = 0; b < N; b++) begin
            for (int m = 0; m < 2; m++) begin
                for (int d = 0; d < 2; d++) begin
                    logic [N-1:0] bit_v, mval;
                    logic routed, e_irq;
                    bit_v = 13'(1) << b;
                    mval  = (m == 1) ? bit_v : ~bit_v;
                    routed = (d == 1) && (b == 5 || b == 6);
                    e_irq = (m == 0) && !routed;
                    mask_we_i = 1'b1; mask_data_i = mval; dma_en_i = d[0];
                    clr_we_i = 1'b1; clr_data_i = '1;
                    tick();
                    mask_we_i = 1'b0; clr_we_i = 1'b0; clr_data_i = '0;
                    event_i = bit_v;
                    tick();
                    event_i = '0;
                    chk("R2 req set", 32'(req_o), 32'(bit_v));
                    chk("R4 mask readback", 32'(mask_o), 32'(mval));
                    tick();
                    chk("R5 R6 irq", 32'(irq_o), 32'(e_irq));
                    chk("R6 R7 rx", 32'(dma_rx_req_o), 32'((d == 1) && (b == 5)));
                    chk("R6 R7 tx", 32'(dma_tx_req_o), 32'((d == 1) && (b == 6)));
                    tick();
                    chk("R2 req sticky", 32'(req_o), 32'(bit_v));
                end
            end
        end

        // R3 clear and set priority
        dma_en_i = 1'b0; mask_we_i = 1'b1; mask_data_i = '0;
        clr_we_i = 1'b1; clr_data_i = '1;
        tick();
        mask_we_i = 1'b0; clr_we_i = 1'b0; clr_data_i = '0;
        event_i = (13'(1) << 3) | (13'(1) << 9);
        tick();
        event_i = 13'(1) << 3; clr_we_i = 1'b1; clr_data_i = 13'(1) << 3;
        tick();
        event_i = '0; clr_we_i = 1'b0; clr_data_i = '0;
        chk("R3 set beats clear", 32'(req_o), 32'((13'(1) << 3) | (13'(1) << 9)));
        clr_we_i = 1'b1; clr_data_i = 13'(1) << 3;
        tick();
        clr_we_i = 1'b0; clr_data_i = '0;
        chk("R3 clear only selected", 32'(req_o), 32'(13'(1) << 9));
        clr_we_i = 1'b1; clr_data_i = '1;
        tick();
        clr_we_i = 1'b0; clr_data_i = '0;
        tick();
        chk("R3 R5 all cleared irq low", {31'd0, irq_o}, 0);

        // R9 stop
        clk_wr_i = 1'b1; clk_data_i = 2'b01;
        tick();
        clk_wr_i = 1'b0; clk_data_i = 2'b00;
        chk("R9 stop run", 32'(clk_run_o), 0);
        chk("R9 stop clkoff req", 32'(req_o), 32'(13'(1) << 4));
        chk("R9 abort pulse", 32'(xfer_abort_o), 1);
        tick();
        chk("R9 abort one cycle", 32'(xfer_abort_o), 0);
        chk("R5 clkoff irq", 32'(irq_o), 1);
        // R8 start
        clk_wr_i = 1'b1; clk_data_i = 2'b10;
        tick();
        clk_wr_i = 1'b0; clk_data_i = 2'b00;
        chk("R8 start run", 32'(clk_run_o), 1);
        chk("R8 start clears clkoff", 32'(req_o), 0);
        chk("R8 no abort", 32'(xfer_abort_o), 0);
        tick();
        chk("R8 irq drops", 32'(irq_o), 0);
        // R9 both bits: stop wins
        clk_wr_i = 1'b1; clk_data_i = 2'b11;
        tick();
        clk_wr_i = 1'b0; clk_data_i = 2'b00;
        chk("R9 both stop wins run", 32'(clk_run_o), 0);
        chk("R9 both stop wins req", 32'(req_o), 32'(13'(1) << 4));

        // R6 dma lines follow level then drop with the request
        dma_en_i = 1'b1;
        event_i = (13'(1) << 5) | (13'(1) << 6);
        tick();
        event_i = '0;
        tick();
        chk("R6 both dma lines", {30'd0, dma_rx_req_o, dma_tx_req_o}, 3);
        chk("R6 irq only clkoff", 32'(irq_o), 1);
        clr_we_i = 1'b1; clr_data_i = 13'(1) << 5;
        tick();
        clr_we_i = 1'b0; clr_data_i = '0;
        tick();
        chk("R6 rx drops tx holds", {30'd0, dma_rx_req_o, dma_tx_req_o}, 1);
        dma_en_i = 1'b0;
        tick(); tick();
        chk("R7 dma off quiet", {30'd0, dma_rx_req_o, dma_tx_req_o}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule